// File: doc/BRIEF.md
# Descriptor-Driven Burst Read Sequencer

The sequencer accepts one transfer descriptor at a time and fetches the data it names. It reads that data through a 512-bit memory-mapped read master and forwards every returned beat on a streaming output. A memory descriptor gives a source address, an 18-bit dword count and a flag that holds the address fixed. The dword count is cut into bursts of up to eight full beats. A trailing partial beat, if any, is issued as its own single-beat burst with byte enables for only the remaining dwords. While bursts are issued, the sequencer respects a waitrequest allowance and a cap on outstanding read beats.

An immediate descriptor carries one or two dwords of payload inside itself. For such a descriptor the sequencer issues no read and emits a single output beat. Once every expected beat has come back, or the immediate beat has gone out, a one-cycle done pulse closes the descriptor. An error flag accompanies the pulse when the descriptor was malformed or when any read response was bad.

Top module: `burst_read_sequencer`

## Requirements
- R1: A descriptor is taken only while `descReady` is high. `descReady` is high after reset and low from the cycle after acceptance until the descriptor finishes.
- R2: Whole 64-byte beats are requested in bursts of min(remaining, 8) beats, in order. `rdBurstCount` is 1 to 8 and every burst longer than one beat has all 64 byte enables set.
- R3: When the dword count is not a multiple of 16, the last beat is requested as a separate 1-beat burst. Byte-enable bits [4n-1:0] are set, where n is the count modulo 16. The forwarded last beat carries the same `outKeep`.
- R4: With `descFixedSrc` clear, each burst starts 64 bytes per beat after the previous burst. With it set, every burst uses the descriptor's address.
- R5: A memory descriptor whose address has any of bits [5:0] set, or whose dword count is zero, issues no read. `doneStrobe` and `doneError` are then high in the cycle after acceptance.
- R6: An immediate descriptor with a count of 1 or 2 issues no read. Two cycles after acceptance it emits one beat together with `doneStrobe`, with `outLast` set and `doneError` low. The beat holds `descImmData[31:0]` (count 1, `outKeep`=0xF) or `descImmData[63:0]` (count 2, `outKeep`=0xFF), with all other data bits zero.
- R7: An immediate descriptor with a count other than 1 or 2, or with a count of 2 where address bits [11:0] exceed 0xFF8 (the 8 bytes would cross a 4 KB page), emits nothing. It ends with `doneStrobe` and `doneError` in the cycle after acceptance.
- R8: While `rdWaitRequest` stays high, at most 4 read commands are asserted. Issuing resumes after it falls.
- R9: Requested but not yet returned read beats never exceed 128.
- R10: Each returned beat appears on `outData` one cycle after it is presented, in order, with `outKeep` all ones except as in R3. `outLast` marks the final beat and coincides with `doneStrobe`.
- R11: A non-zero `rdResponse` on any beat sets `doneError` for that descriptor. All remaining beats are still collected and forwarded before done.
- R12: `doneStrobe` lasts exactly one cycle, and `descReady` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Sequencer idle, descriptor taken this cycle if valid |
| descSrcAddr | input | 64 | Source byte address |
| descDwords | input | 18 | Transfer length in dwords |
| descFixedSrc | input | 1 | Keep the same source address for every burst |
| descImmed | input | 1 | Payload is carried in the descriptor |
| descImmData | input | 64 | Immediate payload |
| rdRead | output | 1 | Read command |
| rdAddress | output | 64 | Burst start address |
| rdBurstCount | output | 4 | Beats in the burst |
| rdByteEnable | output | 64 | Byte enables of the burst |
| rdWaitRequest | input | 1 | Slave back-pressure (allowance of 4) |
| rdDataValid | input | 1 | Read data beat present |
| rdData | input | 512 | Read data |
| rdResponse | input | 2 | Beat status, zero means good |
| outValid | output | 1 | Forwarded beat valid |
| outData | output | 512 | Forwarded beat |
| outKeep | output | 64 | Valid bytes of the forwarded beat |
| outLast | output | 1 | Final beat of the descriptor |
| doneStrobe | output | 1 | Descriptor finished |
| doneError | output | 1 | Error flag, valid with doneStrobe |

## Verification
Read commands come straight from registered state. The bench therefore compares each command against its own burst list in the cycle the command is offered, and pairs it with the waitrequest level it drives for that same edge. A returned beat is due on the output one cycle after the edge that takes it, so the bench queues its expected beat at that edge and pops the queue at the next sample point. Rejected descriptors must show done in the first sample after the accepting edge, and good immediates in the second. The bench counts those sample points exactly. For memory descriptors done is checked in the very sample that shows the last beat.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int BURST_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_IMM, ST_DONE} seqState_t;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic issue;
    logic beat;
    logic emitImm;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic [BURST_W-1:0] burstLen;
    logic               lastRx;
    logic               badDesc;
    logic               isImm;
  } dpStatus_t;
endpackage

// File: rtl/brs_control.sv
module brs_control
  import brs_pkg::*;
#(
  parameter int MAX_BURST   = 8,
  parameter int WAIT_ALLOW  = 4,
  parameter int MAX_PENDING = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       descValid,
  output logic       descReady,
  input  logic       rdWaitRequest,
  input  logic       rdDataValid,
  input  dpStatus_t  status,
  output seqStrobe_t strobe,
  output logic       rdRead,
  output logic       doneStrobe
);
  localparam int WC_W   = $clog2(WAIT_ALLOW + 1);
  localparam int PEND_W = $clog2(MAX_PENDING + 1);
  localparam int PSUM_W = PEND_W + 1;

  seqState_t         state, stateNext;
  logic [WC_W-1:0]   waitCnt;
  logic [PEND_W-1:0] pending;
  logic              canIssue;
  logic [PSUM_W-1:0] pendingAfter;

  assign descReady    = (state == ST_IDLE);
  assign doneStrobe   = (state == ST_DONE);
  assign pendingAfter = PSUM_W'(pending) + PSUM_W'(status.burstLen);
  assign canIssue     = (state == ST_ISSUE) && (status.burstLen != '0) &&
                        (waitCnt < WC_W'(WAIT_ALLOW)) &&
                        (pendingAfter <= PSUM_W'(MAX_PENDING));
  assign rdRead       = canIssue;

  always_comb begin
    strobe.load    = descReady && descValid;
    strobe.issue   = canIssue;
    strobe.beat    = (state == ST_ISSUE) && rdDataValid;
    strobe.emitImm = (state == ST_IMM);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobe.load)
                  stateNext = status.badDesc ? ST_DONE : (status.isImm ? ST_IMM : ST_ISSUE);
      ST_ISSUE: if (strobe.beat && status.lastRx) stateNext = ST_DONE;
      ST_IMM:   stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      pending <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= rdWaitRequest ? waitCnt + WC_W'(canIssue) : '0;
      pending <= pending + (canIssue ? PEND_W'(status.burstLen) : '0)
                         - (strobe.beat ? PEND_W'(1) : '0);
    end
  end

  assert_pending_cap_R9: assert property (@(posedge clk) disable iff (!rstN)
    pending <= PEND_W'(MAX_PENDING));
  assert_wait_allowance_R8: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WC_W'(WAIT_ALLOW));
  assert_burst_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdRead |-> (status.burstLen >= 1 && status.burstLen <= BURST_W'(MAX_BURST)));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> (!doneStrobe && descReady));
endmodule

// File: rtl/brs_datapath.sv
module brs_datapath
  import brs_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 512,
  parameter int DW_CNT_W  = 18,
  parameter int MAX_BURST = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   descSrcAddr,
  input  logic [DW_CNT_W-1:0] descDwords,
  input  logic                descFixedSrc,
  input  logic                descImmed,
  input  logic [63:0]         descImmData,
  input  logic [DATA_W-1:0]   rdData,
  input  logic [1:0]          rdResponse,
  output dpStatus_t           status,
  output logic [ADDR_W-1:0]   rdAddress,
  output logic [BURST_W-1:0]  rdBurstCount,
  output logic [DATA_W/8-1:0] rdByteEnable,
  output logic                outValid,
  output logic [DATA_W-1:0]   outData,
  output logic [DATA_W/8-1:0] outKeep,
  output logic                outLast,
  output logic                doneError
);
  localparam int BYTES       = DATA_W / 8;
  localparam int DW_PER_BEAT = DATA_W / 32;
  localparam int OFF_W       = $clog2(BYTES);
  localparam int REM_W       = $clog2(DW_PER_BEAT);
  localparam int BEAT_W      = DW_CNT_W - REM_W + 1;
  localparam int PAGE_W      = 12;
  localparam logic [PAGE_W-1:0] PAGE_LAST8 = PAGE_W'((1 << PAGE_W) - 8);

  logic [ADDR_W-1:0] addrQ;
  logic [BEAT_W-1:0] fullLeftQ, rxLeftQ;
  logic [REM_W-1:0]  remQ;
  logic              remPendQ, fixedQ, immTwoQ, errQ;
  logic [63:0]       immDataQ;
  logic              badImm, badMem;
  logic [BURST_W-1:0] burstLen;

  function automatic logic [BYTES-1:0] dwMask(input logic [REM_W-1:0] n);
    logic [BYTES-1:0] m;
    for (int i = 0; i < BYTES; i++) m[i] = (i < 4 * int'(n));
    return m;
  endfunction

  assign badImm = descImmed && ((descDwords == '0) || (descDwords > DW_CNT_W'(2)) ||
                  ((descDwords == DW_CNT_W'(2)) && (descSrcAddr[PAGE_W-1:0] > PAGE_LAST8)));
  assign badMem = !descImmed && ((descDwords == '0) || (descSrcAddr[OFF_W-1:0] != '0));

  always_comb begin
    if (fullLeftQ != '0)
      burstLen = (fullLeftQ >= BEAT_W'(MAX_BURST)) ? BURST_W'(MAX_BURST) : BURST_W'(fullLeftQ);
    else
      burstLen = remPendQ ? BURST_W'(1) : '0;
    status.burstLen = burstLen;
    status.lastRx   = (rxLeftQ == BEAT_W'(1));
    status.badDesc  = badImm || badMem;
    status.isImm    = descImmed;
  end

  assign rdAddress    = addrQ;
  assign rdBurstCount = burstLen;
  assign rdByteEnable = (fullLeftQ != '0) ? '1 : dwMask(remQ);
  assign doneError    = errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; fullLeftQ <= '0; rxLeftQ <= '0; remQ <= '0;
      remPendQ <= 1'b0; fixedQ <= 1'b0; immTwoQ <= 1'b0; errQ <= 1'b0;
      immDataQ <= '0; outValid <= 1'b0; outData <= '0; outKeep <= '0; outLast <= 1'b0;
    end else begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      if (strobe.load) begin
        addrQ     <= descSrcAddr;
        fullLeftQ <= BEAT_W'(descDwords[DW_CNT_W-1:REM_W]);
        remQ      <= descDwords[REM_W-1:0];
        remPendQ  <= (descDwords[REM_W-1:0] != '0);
        rxLeftQ   <= BEAT_W'(descDwords[DW_CNT_W-1:REM_W]) +
                     BEAT_W'(descDwords[REM_W-1:0] != '0);
        fixedQ    <= descFixedSrc;
        immDataQ  <= descImmData;
        immTwoQ   <= (descDwords == DW_CNT_W'(2));
        errQ      <= badImm || badMem;
      end
      if (strobe.issue) begin
        if (fullLeftQ != '0) fullLeftQ <= fullLeftQ - BEAT_W'(burstLen);
        else                 remPendQ  <= 1'b0;
        if (!fixedQ) addrQ <= addrQ + (ADDR_W'(burstLen) << OFF_W);
      end
      if (strobe.beat) begin
        rxLeftQ  <= rxLeftQ - BEAT_W'(1);
        outValid <= 1'b1;
        outData  <= rdData;
        outKeep  <= ((rxLeftQ == BEAT_W'(1)) && (remQ != '0)) ? dwMask(remQ) : '1;
        outLast  <= (rxLeftQ == BEAT_W'(1));
        if (rdResponse != 2'b00) errQ <= 1'b1;
      end
      if (strobe.emitImm) begin
        outValid <= 1'b1;
        outData  <= DATA_W'(immTwoQ ? immDataQ : {32'b0, immDataQ[31:0]});
        outKeep  <= immTwoQ ? BYTES'(8'hFF) : BYTES'(4'hF);
        outLast  <= 1'b1;
      end
    end
  end

  assert_fixed_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fixedQ && !strobe.load) |=> $stable(rdAddress));
  assert_full_enables_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && rdBurstCount > BURST_W'(1)) |-> (&rdByteEnable));
  assert_last_has_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
endmodule

// File: rtl/burst_read_sequencer.sv
module burst_read_sequencer
  import brs_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int DATA_W      = 512,
  parameter int DW_CNT_W    = 18,
  parameter int MAX_BURST   = 8,
  parameter int WAIT_ALLOW  = 4,
  parameter int MAX_PENDING = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                descValid,
  output logic                descReady,
  input  logic [ADDR_W-1:0]   descSrcAddr,
  input  logic [DW_CNT_W-1:0] descDwords,
  input  logic                descFixedSrc,
  input  logic                descImmed,
  input  logic [63:0]         descImmData,
  output logic                rdRead,
  output logic [ADDR_W-1:0]   rdAddress,
  output logic [BURST_W-1:0]  rdBurstCount,
  output logic [DATA_W/8-1:0] rdByteEnable,
  input  logic                rdWaitRequest,
  input  logic                rdDataValid,
  input  logic [DATA_W-1:0]   rdData,
  input  logic [1:0]          rdResponse,
  output logic                outValid,
  output logic [DATA_W-1:0]   outData,
  output logic [DATA_W/8-1:0] outKeep,
  output logic                outLast,
  output logic                doneStrobe,
  output logic                doneError
);
  seqStrobe_t strobe;
  dpStatus_t  status;

  brs_control #(.MAX_BURST(MAX_BURST), .WAIT_ALLOW(WAIT_ALLOW), .MAX_PENDING(MAX_PENDING)) u_ctrl (
    .clk(clk), .rstN(rstN), .descValid(descValid), .descReady(descReady),
    .rdWaitRequest(rdWaitRequest), .rdDataValid(rdDataValid), .status(status),
    .strobe(strobe), .rdRead(rdRead), .doneStrobe(doneStrobe)
  );

  brs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DW_CNT_W(DW_CNT_W), .MAX_BURST(MAX_BURST)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .descSrcAddr(descSrcAddr),
    .descDwords(descDwords), .descFixedSrc(descFixedSrc), .descImmed(descImmed),
    .descImmData(descImmData), .rdData(rdData), .rdResponse(rdResponse), .status(status),
    .rdAddress(rdAddress), .rdBurstCount(rdBurstCount), .rdByteEnable(rdByteEnable),
    .outValid(outValid), .outData(outData), .outKeep(outKeep), .outLast(outLast),
    .doneError(doneError)
  );
endmodule

// File: tb/tb_burst_read_sequencer.sv
module tb_burst_read_sequencer;
  localparam int CLK_PERIOD = 10;

  logic         clk, rstN, descValid, descReady, descFixedSrc, descImmed;
  logic [63:0]  descSrcAddr, descImmData;
  logic [17:0]  descDwords;
  logic         rdRead, rdWaitRequest, rdDataValid;
  logic [63:0]  rdAddress, rdByteEnable, outKeep;
  logic [3:0]   rdBurstCount;
  logic [511:0] rdData, outData;
  logic [1:0]   rdResponse;
  logic         outValid, outLast, doneStrobe, doneError;

  burst_read_sequencer dut (
    .clk(clk), .rstN(rstN), .descValid(descValid), .descReady(descReady),
    .descSrcAddr(descSrcAddr), .descDwords(descDwords), .descFixedSrc(descFixedSrc),
    .descImmed(descImmed), .descImmData(descImmData), .rdRead(rdRead),
    .rdAddress(rdAddress), .rdBurstCount(rdBurstCount), .rdByteEnable(rdByteEnable),
    .rdWaitRequest(rdWaitRequest), .rdDataValid(rdDataValid), .rdData(rdData),
    .rdResponse(rdResponse), .outValid(outValid), .outData(outData), .outKeep(outKeep),
    .outLast(outLast), .doneStrobe(doneStrobe), .doneError(doneError)
  );

  typedef struct { logic [63:0] a; int len; logic [63:0] be; } cmd_t;
  typedef struct { logic [511:0] d; logic [63:0] k; logic l; } beat_t;

  cmd_t  expCmd[$];
  beat_t expOut[$];
  int    pendQ[$];
  int    nChecks = 0, nFail = 0;
  int    cmdBad, outBad, pend, maxPend, hiRun, maxHi, descCycle, beatNo;
  int    totalBeats, remDw, errBeat, wrMode;
  bit    stall;
  logic [15:0] tag = 16'h0;

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end

  function automatic logic [63:0] maskOf(int n);
    if (n >= 16) return '1;
    return (64'd1 << (n * 4)) - 64'd1;
  endfunction

  function automatic logic [511:0] patOf(logic [15:0] t, int b);
    return {16{t, 16'(b)}};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // read slave model and output monitor, one step per falling edge
  task automatic monitorStep();
    beat_t e;
    cmd_t  c;
    int    b;
    descCycle++;
    if (outValid) begin
      if (expOut.size() == 0) outBad++;
      else begin
        e = expOut.pop_front();
        if (outData !== e.d || outKeep !== e.k || outLast !== e.l) outBad++;
      end
    end
    case (wrMode)
      1: rdWaitRequest = (($urandom % 4) == 0);
      2: rdWaitRequest = (descCycle < 20);
      default: rdWaitRequest = 1'b0;
    endcase
    if (!rdWaitRequest) hiRun = 0;
    else if (rdRead) hiRun++;
    if (hiRun > maxHi) maxHi = hiRun;
    rdDataValid = 1'b0; rdResponse = 2'b00; rdData = '0;
    if (pendQ.size() > 0 && !(stall && descCycle < 300) && ($urandom % 3) != 0) begin
      b = pendQ.pop_front();
      rdDataValid = 1'b1;
      rdData = patOf(tag, b);
      rdResponse = (b == errBeat) ? 2'b10 : 2'b00;
      e.d = patOf(tag, b);
      e.k = (b == totalBeats - 1 && remDw != 0) ? maskOf(remDw) : '1;
      e.l = (b == totalBeats - 1);
      expOut.push_back(e);
      pend--;
    end
    if (rdRead) begin
      if (expCmd.size() == 0) cmdBad++;
      else begin
        c = expCmd.pop_front();
        if (rdAddress !== c.a || int'(rdBurstCount) != c.len || rdByteEnable !== c.be) cmdBad++;
      end
      for (int i = 0; i < int'(rdBurstCount); i++) begin pendQ.push_back(beatNo); beatNo++; end
      pend += int'(rdBurstCount);
      if (pend > maxPend) maxPend = pend;
    end
  endtask

  initial begin
    rdWaitRequest = 0; rdDataValid = 0; rdData = '0; rdResponse = 0; wrMode = 0;
    @(posedge rstN);
    forever begin @(negedge clk); monitorStep(); end
  end

  task automatic runDesc(logic [63:0] addr, int dw, bit fixed, bit imm, logic [63:0] immD,
                         int eb, bit stl, int wm, string req);
    bit bad, expErr;
    int full, l, cyc;
    logic [63:0] a;
    beat_t e;
    cmd_t c;
    expCmd.delete(); expOut.delete(); pendQ.delete();
    cmdBad = 0; outBad = 0; pend = 0; maxPend = 0; hiRun = 0; maxHi = 0; descCycle = 0; beatNo = 0;
    totalBeats = dw / 16 + ((dw % 16) != 0 ? 1 : 0); remDw = dw % 16;
    errBeat = eb; stall = stl; wrMode = wm; tag = tag + 16'd1;
    bad = imm ? (dw < 1 || dw > 2 || (dw == 2 && addr[11:0] > 12'hFF8))
              : (dw == 0 || addr[5:0] != 6'd0);
    expErr = bad || (!imm && eb >= 0 && eb < totalBeats);
    if (!imm && !bad) begin
      full = dw / 16; a = addr;
      while (full > 0) begin
        l = (full > 8) ? 8 : full;
        c.a = a; c.len = l; c.be = '1; expCmd.push_back(c);
        full -= l;
        if (!fixed) a = a + 64'(l * 64);
      end
      if (remDw != 0) begin c.a = a; c.len = 1; c.be = maskOf(remDw); expCmd.push_back(c); end
    end
    if (imm && !bad) begin
      e.d = (dw == 2) ? 512'(immD) : 512'(immD[31:0]);
      e.k = (dw == 2) ? 64'hFF : 64'hF; e.l = 1'b1;
      expOut.push_back(e);
    end
    check(descReady == 1'b1, "R12", "ready before descriptor", descReady, 1);
    descSrcAddr = addr; descDwords = 18'(dw); descFixedSrc = fixed; descImmed = imm;
    descImmData = immD; descValid = 1'b1;
    @(negedge clk);
    descValid = 1'b0;
    check(descReady == 1'b0, "R1", "ready while busy", descReady, 0);
    cyc = 1;
    while (!doneStrobe && cyc < 20000) begin @(negedge clk); cyc++; end
    check(doneStrobe == 1'b1, "R12", "done seen", doneStrobe, 1);
    check(doneError == expErr, req, "done error flag", doneError, expErr);
    if (bad) check(cyc == 1, imm ? "R7" : "R5", "cycles to done", cyc, 1);
    else if (imm) check(cyc == 2 && outValid && outLast, "R6", "immediate beat with done", cyc, 2);
    else check(outValid && outLast, "R10", "last beat with done", {outValid, outLast}, 3);
    @(negedge clk);
    check(descReady && !doneStrobe, "R12", "single done then ready", {descReady, doneStrobe}, 2);
    check(cmdBad == 0 && expCmd.size() == 0, "R2/R3/R4", "command mismatches",
          cmdBad + expCmd.size(), 0);
    check(outBad == 0 && expOut.size() == 0, imm ? "R6" : "R10", "output beat mismatches",
          outBad + expOut.size(), 0);
    check(maxPend <= 128, "R9", "max outstanding beats", maxPend, 128);
    check(maxHi <= 4, "R8", "reads under waitrequest", maxHi, 4);
  endtask

  initial begin
    void'($urandom(32'd7));
    rstN = 0; descValid = 0; descSrcAddr = 0; descDwords = 0; descFixedSrc = 0;
    descImmed = 0; descImmData = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(descReady && !rdRead && !outValid && !doneStrobe, "R1", "reset state",
          {descReady, rdRead, outValid, doneStrobe}, 8);

    runDesc(64'h1000, 1, 0, 1, 64'hCAFE_F00D_1234_5678, -1, 0, 0, "R6");
    runDesc(64'h1FF8, 2, 0, 1, 64'hA5A5_0F0F_DEAD_BEEF, -1, 0, 0, "R6");
    runDesc(64'h1FFC, 2, 0, 1, 64'h1111_2222_3333_4444, -1, 0, 0, "R7");
    runDesc(64'h2000, 3, 0, 1, 64'h5, -1, 0, 0, "R7");
    runDesc(64'h3010, 64, 1, 0, 64'h0, -1, 0, 0, "R5");
    runDesc(64'h4000, 0, 0, 0, 64'h0, -1, 0, 0, "R5");
    runDesc(64'h5000, 128, 0, 0, 64'h0, -1, 0, 0, "R2");
    runDesc(64'h6000, 16 * 20 + 5, 0, 0, 64'h0, -1, 0, 1, "R3");
    runDesc(64'h7040, 16 * 13 + 7, 1, 0, 64'h0, -1, 0, 1, "R4");
    runDesc(64'h8000, 16 * 40, 0, 0, 64'h0, 3, 0, 1, "R11");
    runDesc(64'h9000, 16 * 64, 0, 0, 64'h0, -1, 0, 2, "R8");
    check(maxHi == 4, "R8", "allowance fully used", maxHi, 4);
    runDesc(64'hA000, 16 * 300, 0, 0, 64'h0, -1, 1, 0, "R9");
    check(maxPend == 128, "R9", "outstanding reaches cap", maxPend, 128);

    for (int n = 0; n < 20; n++) begin
      logic [63:0] ra;
      int dw, tb, eb;
      bit im;
      im = (($urandom % 5) == 0);
      if (im) begin
        dw = 1 + ($urandom % 2);
        ra = {32'h0, $urandom} & ~64'h3;
        if (($urandom % 2) == 0) ra[11:0] = 12'hFFC;
        runDesc(ra, dw, 0, 1, {$urandom, $urandom}, -1, 0, 0, "R7");
      end else begin
        dw = 1 + ($urandom % 400);
        ra = {$urandom, $urandom} & ~64'h3F;
        tb = dw / 16 + ((dw % 16) != 0 ? 1 : 0);
        eb = (($urandom % 3) == 0) ? int'($urandom % tb) : -1;
        runDesc(ra, dw, ($urandom % 2) == 1, 0, 64'h0, eb, 0, 1, "R11");
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule